// File: doc/BRIEF.md
# Completion Receive Parser With Timeout

This block waits for the answer to one configuration request. After a start pulse from the request side, it watches a 32-bit receive stream. Each beat of the stream carries a valid qualifier and start-of-packet and end-of-packet flags. The block locks onto the first beat that has the start flag and stores the leading dwords of the packet. When the end-of-packet beat arrives, it decodes dword 1 and produces one result.

The result depends on dword 1 and on the request type:

- A completion whose status is not zero gives an error flag. For a read, it also gives an all-ones value.
- A good read completion gives data only when its byte count is exactly four and dword 3 was received.
- A write never produces data. Only the arrival of the completion and its status matter.

If no packet finishes within a fixed number of clock cycles, a timeout pulse is issued in place of a result. The parser then returns to idle. Only one request may be outstanding, so tags are not compared.

Top module: `cpl_rx_parser`

## Requirements
- R1: After reset all outputs are 0 and the parser is idle. Stream beats that arrive before a start pulse produce no done or timeout pulse.
- R2: After start, beats without the start-of-packet flag are ignored. The first valid beat with that flag is stored as dword 0.
- R3: Beats that follow dword 0 are stored in order as dword 1, dword 2 and so on. The packet ends with the first valid beat that has the end-of-packet flag. `res_done_o` pulses in the cycle after the clock edge that accepts that beat. A beat carrying both flags is a complete one-dword packet.
- R4: The completion status is dword 1 bits 15:13 and the byte count is dword 1 bits 11:0. If the status is not zero, `res_status_err_o` is 1. For a read, `res_data_vld_o` is also 1 and `res_data_o` is 0xFFFFFFFF.
- R5: A read is good when its status is 0, its byte count is 4 and at least four dwords were received. A good read gives `res_data_vld_o`=1 and `res_data_o` equal to dword 3.
- R6: A read with status 0 whose byte count differs from 4, or that has fewer than four dwords, still pulses done. It gives `res_data_vld_o`=0 and `res_data_o`=0.
- R7: Dwords after dword 3 are discarded, but they still count toward the packet. A six-beat packet ends on its end-of-packet beat and returns dword 3.
- R8: For a write request (`is_write_i`=1 at start), `res_data_vld_o` and `res_data_o` stay 0. `res_status_err_o` reflects the status.
- R9: Start edge E0 is the clock edge that accepts the start pulse. If no end-of-packet beat is accepted on edges E1 to E(POLL_LIMIT), `res_timeout_o` pulses after edge E(POLL_LIMIT). The parser then returns to idle and ignores later beats. POLL_LIMIT defaults to 20000.
- R10: Done and timeout are one-cycle pulses and are never high together. An end-of-packet beat accepted on edge E(POLL_LIMIT) yields done, not timeout.
- R11: A start pulse while a request is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request issued; arms the parser when idle |
| is_write_i | input | 1 | Request type, sampled with start_i (1 = write) |
| rx_valid_i | input | 1 | Receive beat qualifier |
| rx_sop_i | input | 1 | Beat is the first of a packet |
| rx_eop_i | input | 1 | Beat is the last of a packet |
| rx_data_i | input | 32 | Receive dword |
| res_done_o | output | 1 | One-cycle pulse: a completion was parsed |
| res_timeout_o | output | 1 | One-cycle pulse: poll limit reached without a completion |
| res_data_vld_o | output | 1 | Result value is present (with done) |
| res_status_err_o | output | 1 | Completion status was not zero (with done) |
| res_data_o | output | 32 | Read value, all ones on error |

## Verification
The end of a packet and the expiry of the poll limit can land on the same clock edge. This happens when the end-of-packet beat is accepted on the final allowed poll step. The bench provokes it by starting a request and then waiting POLL_LIMIT-4 cycles before it sends a four-beat read packet. The packet's last beat therefore arrives exactly on edge E(POLL_LIMIT). The bench expects done with the dword-3 data and no timeout. A second run shifts the same packet one cycle later. The bench then expects the timeout pulse on edge E(POLL_LIMIT) and expects the late end-of-packet beat to be ignored.

// File: rtl/cpl_rx_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the completion receive parser: the control states
// and the dword 1 field positions decoded by the result builder.
package cpl_rx_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,   // no request pending
        PS_HUNT = 2'd1,   // waiting for a start-of-packet beat
        PS_BODY = 2'd2    // collecting beats until end-of-packet
    } parse_state_e;

    localparam int STAT_MSB      = 15;  // completion status, top bit
    localparam int STAT_LSB      = 13;  // completion status, bottom bit
    localparam int BCNT_W        = 12;  // byte count occupies bits BCNT_W-1:0
    localparam int GOOD_BCNT     = 4;   // byte count that carries read data
    localparam int HDR_IDX       = 1;   // dword holding status and byte count
    localparam int PAYLOAD_IDX   = 3;   // dword holding the read value

endpackage

// File: rtl/cpl_dword_capture.sv
`timescale 1ns/1ps
// Stores the first KEEP_DW dwords of a packet and counts the accepted beats.
// It assumes beat_en is asserted only for beats the controller accepts, and
// first_beat marks the start-of-packet beat. The next-state values are also
// driven out, so the packet can be decoded on the edge that takes its last beat.
module cpl_dword_capture #(
    parameter int DATA_W  = 32,
    parameter int KEEP_DW = 4,
    parameter int CNT_W   = $clog2(KEEP_DW + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           beat_en,
    input  logic                           first_beat,
    input  logic [DATA_W-1:0]              beat_data,
    output logic [KEEP_DW-1:0][DATA_W-1:0] dw_nx_o,
    output logic [CNT_W-1:0]               cnt_nx_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(KEEP_DW);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    // Beat count: restarts at 1 on the start-of-packet beat and saturates at KEEP_DW.
    always_comb begin
        cnt_nx = cnt_q;
        if (beat_en) begin
            if (first_beat)
                cnt_nx = CNT_W'(1);
            else if (cnt_q != CNT_MAX)
                cnt_nx = cnt_q + CNT_W'(1);
        end
    end

    // Beat count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nx;
    end

    assign cnt_nx_o = cnt_nx;

    // One storage slot per kept dword.
    for (genvar i = 0; i < KEEP_DW; i++) begin : g_slot
        logic              hit;
        logic [DATA_W-1:0] slot_q;
        logic [DATA_W-1:0] slot_nx;

        assign hit = beat_en && (first_beat ? (i == 0) : (cnt_q == CNT_W'(i)));

        // Slot update: take the beat on a hit, and clear on a new packet.
        always_comb begin
            if (hit)
                slot_nx = beat_data;
            else if (beat_en && first_beat)
                slot_nx = '0;
            else
                slot_nx = slot_q;
        end

        // Slot register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else
                slot_q <= slot_nx;
        end

        assign dw_nx_o[i] = slot_nx;
    end

endmodule

// File: rtl/cpl_poll_timer.sv
`timescale 1ns/1ps
// Counts the poll steps of one pending request. It assumes clear is pulsed
// on the start edge and run stays high while the request is pending.
// expire_o is high on the LIMIT-th run cycle after the clear.
module cpl_poll_timer #(
    parameter int LIMIT = 20000,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expire_o
);

    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = run && (cnt_q == LAST_STEP);

    // Step counter: cleared on start, advanced once per pending cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (run && !expire_o)
            cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/cpl_result_builder.sv
`timescale 1ns/1ps
// Decodes dword 1 of a finished packet and registers the result port.
// It assumes fire_i is high for exactly the edge that accepts the
// end-of-packet beat, with dw1_i, dw3_i and cnt_i showing the stored state
// after that beat. A finishing packet wins over an expiring timer.
module cpl_result_builder
    import cpl_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              expire_i,
    input  logic              is_write_i,
    input  logic [DATA_W-1:0] dw1_i,
    input  logic [DATA_W-1:0] dw3_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              done_o,
    output logic              timeout_o,
    output logic              data_vld_o,
    output logic              status_err_o,
    output logic [DATA_W-1:0] data_o
);

    logic [STAT_MSB-STAT_LSB:0] status;
    logic [BCNT_W-1:0]          bcnt;
    logic                       err;
    logic                       has_payload;
    logic                       read_ok;

    // Field decode of dword 1 and the data-return conditions.
    always_comb begin
        status      = dw1_i[STAT_MSB:STAT_LSB];
        bcnt        = dw1_i[BCNT_W-1:0];
        err         = |status;
        has_payload = cnt_i > CNT_W'(PAYLOAD_IDX);
        read_ok     = !is_write_i && !err && has_payload && (bcnt == BCNT_W'(GOOD_BCNT));
    end

    // Result registers: one-cycle pulses, with the value fields cleared when no result is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o       <= 1'b0;
            timeout_o    <= 1'b0;
            data_vld_o   <= 1'b0;
            status_err_o <= 1'b0;
            data_o       <= '0;
        end else begin
            done_o    <= fire_i;
            timeout_o <= expire_i && !fire_i;
            if (fire_i) begin
                status_err_o <= err;
                data_vld_o   <= !is_write_i && (err || read_ok);
                if (!is_write_i && err)
                    data_o <= '1;
                else if (read_ok)
                    data_o <= dw3_i;
                else
                    data_o <= '0;
            end else begin
                status_err_o <= 1'b0;
                data_vld_o   <= 1'b0;
                data_o       <= '0;
            end
        end
    end

endmodule

// File: rtl/cpl_rx_parser.sv
`timescale 1ns/1ps
// Completion receive parser, top level. It arms on a start pulse while
// idle, then hunts for a start-of-packet beat, collects the packet until
// end-of-packet and issues one result. If the poll limit passes first, it
// issues a timeout instead. It assumes a single outstanding request and a
// receive stream that is not back-pressured.
module cpl_rx_parser
    import cpl_rx_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int POLL_LIMIT = 20000,
    parameter int KEEP_DW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_write_i,
    input  logic              rx_valid_i,
    input  logic              rx_sop_i,
    input  logic              rx_eop_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic              res_done_o,
    output logic              res_timeout_o,
    output logic              res_data_vld_o,
    output logic              res_status_err_o,
    output logic [DATA_W-1:0] res_data_o
);

    localparam int CAP_CNT_W = $clog2(KEEP_DW + 1);

    parse_state_e                  state_q;
    parse_state_e                  state_nx;
    logic                          write_q;
    logic                          busy;
    logic                          hunting;
    logic                          arm;
    logic                          accept;
    logic                          fire;
    logic                          expire;
    logic [KEEP_DW-1:0][DATA_W-1:0] dw_nx;
    logic [CAP_CNT_W-1:0]          cnt_nx;

    // Beat acceptance and packet end.
    always_comb begin
        hunting = (state_q == PS_HUNT);
        busy    = (state_q != PS_IDLE);
        arm     = (state_q == PS_IDLE) && start_i;
        accept  = rx_valid_i && ((hunting && rx_sop_i) || (state_q == PS_BODY));
        fire    = accept && rx_eop_i;
    end

    // Next state: a finishing packet wins over the timer.
    always_comb begin
        state_nx = state_q;
        case (state_q)
            PS_IDLE: if (start_i) state_nx = PS_HUNT;
            PS_HUNT: begin
                if (fire || expire)
                    state_nx = PS_IDLE;
                else if (accept)
                    state_nx = PS_BODY;
            end
            PS_BODY: if (fire || expire) state_nx = PS_IDLE;
            default: state_nx = PS_IDLE;
        endcase
    end

    // State register and request-type latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            write_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (arm)
                write_q <= is_write_i;
        end
    end

    cpl_dword_capture #(
        .DATA_W  (DATA_W),
        .KEEP_DW (KEEP_DW),
        .CNT_W   (CAP_CNT_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_en    (accept),
        .first_beat (hunting),
        .beat_data  (rx_data_i),
        .dw_nx_o    (dw_nx),
        .cnt_nx_o   (cnt_nx)
    );

    cpl_poll_timer #(
        .LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (arm),
        .run      (busy),
        .expire_o (expire)
    );

    cpl_result_builder #(
        .DATA_W (DATA_W),
        .CNT_W  (CAP_CNT_W)
    ) u_result (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire_i       (fire),
        .expire_i     (expire),
        .is_write_i   (write_q),
        .dw1_i        (dw_nx[HDR_IDX]),
        .dw3_i        (dw_nx[PAYLOAD_IDX]),
        .cnt_i        (cnt_nx),
        .done_o       (res_done_o),
        .timeout_o    (res_timeout_o),
        .data_vld_o   (res_data_vld_o),
        .status_err_o (res_status_err_o),
        .data_o       (res_data_o)
    );

endmodule

// File: rtl/cpl_rx_parser_chk.sv
`timescale 1ns/1ps
// Protocol checks on the result port of the completion receive parser.
module cpl_rx_parser_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid_i,
    input logic              rx_eop_i,
    input logic              res_done_o,
    input logic              res_timeout_o,
    input logic              res_data_vld_o,
    input logic              res_status_err_o,
    input logic [DATA_W-1:0] res_data_o
);

    p_done_timeout_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_done_o && res_timeout_o));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_done_o |=> !res_done_o);

    p_timeout_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_timeout_o |=> !res_timeout_o);

    p_done_after_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_done_o) |-> $past(rx_valid_i && rx_eop_i));

    p_err_all_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_data_vld_o && res_status_err_o) |-> (res_data_o == {DATA_W{1'b1}}));

    p_value_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_data_vld_o || res_status_err_o) |-> res_done_o);

endmodule

bind cpl_rx_parser cpl_rx_parser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .rx_valid_i       (rx_valid_i),
    .rx_eop_i         (rx_eop_i),
    .res_done_o       (res_done_o),
    .res_timeout_o    (res_timeout_o),
    .res_data_vld_o   (res_data_vld_o),
    .res_status_err_o (res_status_err_o),
    .res_data_o       (res_data_o)
);

// File: tb/cpl_rx_parser_bench.sv
`timescale 1ns/1ps
// Directed bench for the completion receive parser. Inputs change on the
// falling edge and outputs are sampled on the falling edge.
module cpl_rx_parser_bench;

    localparam int LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        is_write_i = 1'b0;
    logic        rx_valid_i = 1'b0;
    logic        rx_sop_i = 1'b0;
    logic        rx_eop_i = 1'b0;
    logic [31:0] rx_data_i = '0;
    logic        res_done_o;
    logic        res_timeout_o;
    logic        res_data_vld_o;
    logic        res_status_err_o;
    logic [31:0] res_data_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cpl_rx_parser #(.POLL_LIMIT(LIMIT)) u_cpl_rx_parser (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .is_write_i       (is_write_i),
        .rx_valid_i       (rx_valid_i),
        .rx_sop_i         (rx_sop_i),
        .rx_eop_i         (rx_eop_i),
        .rx_data_i        (rx_data_i),
        .res_done_o       (res_done_o),
        .res_timeout_o    (res_timeout_o),
        .res_data_vld_o   (res_data_vld_o),
        .res_status_err_o (res_status_err_o),
        .res_data_o       (res_data_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic expect_res(string req, bit d, bit t, bit v, bit e, logic [31:0] data);
        chk(req, "done", 32'(res_done_o), 32'(d));
        chk(req, "timeout", 32'(res_timeout_o), 32'(t));
        chk(req, "data_vld", 32'(res_data_vld_o), 32'(v));
        chk(req, "status_err", 32'(res_status_err_o), 32'(e));
        chk(req, "data", res_data_o, data);
    endtask

    task automatic do_start(bit wr);
        start_i = 1'b1;
        is_write_i = wr;
        @(negedge clk);
        start_i = 1'b0;
        is_write_i = 1'b0;
    endtask

    task automatic beat(logic [31:0] d, bit s, bit e);
        rx_valid_i = 1'b1;
        rx_data_i = d;
        rx_sop_i = s;
        rx_eop_i = e;
        @(negedge clk);
        rx_valid_i = 1'b0;
        rx_sop_i = 1'b0;
        rx_eop_i = 1'b0;
        rx_data_i = '0;
    endtask

    task automatic gap(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_idle();
        expect_res("R1 reset", 0, 0, 0, 0, 32'h0);
        beat(32'h4A00_0001, 1, 1);
        expect_res("R1 idle beat ignored", 0, 0, 0, 0, 32'h0);
        gap(2);
    endtask

    task automatic t_read_good();
        do_start(0);
        beat(32'h1111_1111, 0, 0);
        beat(32'h2222_2222, 0, 1);
        expect_res("R2 non-sop beats ignored", 0, 0, 0, 0, 32'h0);
        beat(32'h4A00_0001, 1, 0);
        beat(32'h0100_0004, 0, 0);
        beat(32'h0000_1D00, 0, 0);
        expect_res("R3 no done before eop", 0, 0, 0, 0, 32'h0);
        beat(32'hDEAD_BEEF, 0, 1);
        expect_res("R5 good read", 1, 0, 1, 0, 32'hDEAD_BEEF);
        @(negedge clk);
        expect_res("R10 done pulse ends", 0, 0, 0, 0, 32'h0);
        gap(2);
    endtask

    task automatic t_status_err();
        do_start(0);
        beat(32'h4A00_0001, 1, 0);
        beat(32'h0000_2004, 0, 0);
        beat(32'h0000_0000, 0, 1);
        expect_res("R4 status error read", 1, 0, 1, 1, 32'hFFFF_FFFF);
        gap(2);
    endtask

    task automatic t_no_data();
        do_start(0);
        beat(32'h4A00_0001, 1, 0);
        beat(32'h0000_0002, 0, 0);
        beat(32'h0000_0000, 0, 0);
        beat(32'h1234_5678, 0, 1);
        expect_res("R6 byte count not four", 1, 0, 0, 0, 32'h0);
        gap(2);
        do_start(0);
        beat(32'h4A00_0001, 1, 0);
        beat(32'h0000_0004, 0, 0);
        beat(32'h0000_0000, 0, 1);
        expect_res("R6 three dwords only", 1, 0, 0, 0, 32'h0);
        gap(2);
        do_start(0);
        beat(32'h4A00_0001, 1, 1);
        expect_res("R3 single beat packet", 1, 0, 0, 0, 32'h0);
        gap(2);
    endtask

    task automatic t_long_packet();
        do_start(0);
        beat(32'h4A00_0001, 1, 0);
        beat(32'h0000_0004, 0, 0);
        beat(32'h0000_0000, 0, 0);
        beat(32'hCAFE_F00D, 0, 0);
        beat(32'h5555_5555, 0, 0);
        expect_res("R7 no done mid packet", 0, 0, 0, 0, 32'h0);
        beat(32'hAAAA_AAAA, 0, 1);
        expect_res("R7 extra dwords discarded", 1, 0, 1, 0, 32'hCAFE_F00D);
        gap(2);
    endtask

    task automatic t_write();
        do_start(1);
        beat(32'h4A00_0000, 1, 0);
        beat(32'h0000_0004, 0, 0);
        beat(32'h0000_0000, 0, 0);
        beat(32'h9999_9999, 0, 1);
        expect_res("R8 write ok", 1, 0, 0, 0, 32'h0);
        gap(2);
        do_start(1);
        beat(32'h4A00_0000, 1, 0);
        beat(32'h0000_8004, 0, 1);
        expect_res("R8 write error", 1, 0, 0, 1, 32'h0);
        gap(2);
    endtask

    task automatic t_restart_ignored();
        do_start(0);
        gap(3);
        do_start(1);
        beat(32'h4A00_0001, 1, 0);
        beat(32'h0000_0004, 0, 0);
        beat(32'h0000_0000, 0, 0);
        beat(32'h0BAD_F00D, 0, 1);
        expect_res("R11 second start ignored", 1, 0, 1, 0, 32'h0BAD_F00D);
        gap(2);
    endtask

    task automatic t_timeout();
        do_start(0);
        gap(LIMIT - 1);
        expect_res("R9 no timeout before limit", 0, 0, 0, 0, 32'h0);
        @(negedge clk);
        expect_res("R9 timeout at limit", 0, 1, 0, 0, 32'h0);
        @(negedge clk);
        expect_res("R10 timeout pulse ends", 0, 0, 0, 0, 32'h0);
        gap(2);
    endtask

    task automatic t_last_step();
        do_start(0);
        gap(LIMIT - 4);
        beat(32'h4A00_0001, 1, 0);
        beat(32'h0000_0004, 0, 0);
        beat(32'h0000_0000, 0, 0);
        beat(32'h7777_0001, 0, 1);
        expect_res("R10 eop on last step wins", 1, 0, 1, 0, 32'h7777_0001);
        gap(2);
    endtask

    task automatic t_late_eop();
        do_start(0);
        gap(LIMIT - 3);
        beat(32'h4A00_0001, 1, 0);
        beat(32'h0000_0004, 0, 0);
        beat(32'h0000_0000, 0, 0);
        expect_res("R9 timeout before late eop", 0, 1, 0, 0, 32'h0);
        beat(32'h7777_0002, 0, 1);
        expect_res("R9 late eop ignored", 0, 0, 0, 0, 32'h0);
        gap(2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        gap(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_idle();
        t_read_good();
        t_status_err();
        t_no_data();
        t_long_packet();
        t_write();
        t_restart_ignored();
        t_timeout();
        t_last_step();
        t_late_eop();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

endmodule